// File: doc/BRIEF.md
# Shared Time-Base and Watchdog Timer

The block derives two timing functions from one binary divider chain: a periodic time-base square wave at one of eight rates, and a watchdog that raises a sticky time-out flag after four time-base periods without a clear. Either function can be steered onto an open-drain interrupt line, or neither. The chain advances on a slow tick enable (nominally 32 kHz). When the system runs from a faster clock, a fast tick enable (nominally 256 kHz) passes through a divide-by-eight prescaler to reach the same slow rate. Software controls everything through single-cycle command strobes from an upstream serial command decoder.

Because the time base and the watchdog share one counter, the commands interact. Stopping the watchdog stops the time base too. Starting either one starts the shared count. The full clear resets the watchdog stages and the count, and the time-base clear resets only the count. A three-state routing machine records which source drives the interrupt line. Its states are `ST_HALT`, where the counter is stopped and nothing is routed, `ST_TIMEBASE`, where the count runs and the time-base level is routed, and `ST_WATCHDOG`, where the count runs and the watchdog flag is routed. The transitions are as follows. Watchdog-stop goes to `ST_HALT` from any state. Watchdog-run goes to `ST_WATCHDOG` from any state. Time-base-route goes to `ST_TIMEBASE` from any state. When strobes coincide, watchdog-stop wins over watchdog-run, and watchdog-run wins over time-base-route. Reset enters `ST_HALT`.

Top module: `tbwd_timer`

## Requirements
- R1: After reset the interrupt enable `irq_oe` and the drive-low output `irq_low` are 0, the system is off, the routing state is `ST_HALT`, and the rate code is 7 (fastest rate).
- R2: With rate code r (0 to 7) and the count N counted from a clear, the time-base level is bit (CNT_W-1-r) of N. In `ST_TIMEBASE` with the interrupt enabled, `irq_low` is 1 exactly while that bit is 0. A period is therefore 2^(CNT_W-r) steps, and the first half-period after a clear is the low half.
- R3: With `fast_src`=0, the count advances once per cycle with `tick_slow` high. With `fast_src`=1, it advances once per eight cycles with `tick_fast` high, and the prescaler restarts on either clear.
- R4: In `ST_WATCHDOG` with the interrupt enabled, `irq_low` rises at the step that completes the fourth time-base period after a full clear, and not before.
- R5: Once set, the watchdog flag holds `irq_low` at 1 until `cmd_clr_all` or `cmd_irq_off` is seen.
- R6: `cmd_wdt_stop` enters `ST_HALT`, which freezes the count and releases `irq_low`. A later route command resumes counting from the frozen value.
- R7: `cmd_tb_route` routes the time-base level to the interrupt line even while the watchdog flag is set.
- R8: `cmd_clr_all` clears the count, the prescaler, the watchdog stages and the flag. `cmd_clr_tb` clears only the count and the prescaler, so watchdog stages already accumulated still count toward the time-out.
- R9: A clear takes priority over a step in the same cycle, so the count is 0 in the cycle after any clear.
- R10: `cmd_irq_off` drops `irq_oe` and clears the watchdog flag. `cmd_irq_on` raises `irq_oe`. If both arrive together, the line ends up disabled.
- R11: While the system is off (after `cmd_sys_off`, until `cmd_sys_on`), neither the count nor the prescaler nor the watchdog advances, and the routed level stays put.
- R12: `irq_low` is never 1 while `irq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_slow | input | 1 | Slow-rate step enable, used when `fast_src`=0 |
| tick_fast | input | 1 | Fast-rate step enable, divided by eight when `fast_src`=1 |
| fast_src | input | 1 | Selects the prescaled fast tick as the step source |
| cmd_sys_on | input | 1 | Strobe: system on, counting allowed |
| cmd_sys_off | input | 1 | Strobe: system off, all counting frozen |
| cmd_wdt_run | input | 1 | Strobe: run the count, route the watchdog flag |
| cmd_wdt_stop | input | 1 | Strobe: stop the count, route nothing |
| cmd_tb_route | input | 1 | Strobe: run the count, route the time-base level |
| cmd_clr_all | input | 1 | Strobe: clear count, prescaler, watchdog stages and flag |
| cmd_clr_tb | input | 1 | Strobe: clear count and prescaler only |
| cmd_irq_on | input | 1 | Strobe: enable the interrupt output |
| cmd_irq_off | input | 1 | Strobe: disable the interrupt output and clear the flag |
| cmd_rate_load | input | 1 | Strobe: load `rate_in` as the rate code |
| rate_in | input | 3 | Rate code, 0 slowest, 7 fastest |
| irq_low | output | 1 | Pull the open-drain interrupt line low |
| irq_oe | output | 1 | Interrupt driver enabled (0 means high impedance) |

## Verification
The time-base output is swept over two full periods at every rate code from the slow tick, and again at two rate codes from the prescaled fast tick. These sweeps separate a wrong bit selection, an off-by-one clear and a wrong prescale ratio. The watchdog is swept to its time-out edge at every rate, which pins the four-period count exactly. A partial clear in mid-count shows whether the stages survive a time-base-only clear. The stop, system-off and resume patterns use a frozen interval whose length is not a multiple of the period, so any count that continued during the freeze shows up as a phase error after resuming. Overlapping enable and disable strobes test the enable priority.

// File: rtl/tbwd_pkg.sv
package tbwd_pkg;

    // Routing of the interrupt source; also decides whether the count runs
    typedef enum logic [1:0] {
        ST_HALT     = 2'd0,
        ST_TIMEBASE = 2'd1,
        ST_WATCHDOG = 2'd2
    } route_e;

endpackage

// File: rtl/tbwd_prescale.sv
module tbwd_prescale #(
    parameter int PRE_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    input  logic fast_src,
    input  logic tick_slow,
    input  logic tick_fast,
    output logic step
);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clear) begin
            pre_q <= '0;
        end else if (run && fast_src && tick_fast) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // One step per slow tick, or one per 2**PRE_W fast ticks
    always_comb begin
        if (fast_src) begin
            step = run && tick_fast && (&pre_q);
        end else begin
            step = run && tick_slow;
        end
    end

endmodule

// File: rtl/tbwd_divider.sv
module tbwd_divider #(
    parameter int CNT_W  = 15,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              clear,
    input  logic [RATE_W-1:0] rate,
    output logic [CNT_W-1:0]  cnt,
    output logic              tb_level,
    output logic              period_end
);

    localparam int IDX_W = $clog2(CNT_W);
    localparam int TOP   = CNT_W - 1;

    logic [IDX_W-1:0] sel;
    logic [CNT_W-1:0] low_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Faster rate codes tap a lower bit of the chain
    always_comb begin
        sel = IDX_W'(TOP) - IDX_W'(rate);
        for (int i = 0; i < CNT_W; i++) begin
            low_mask[i] = (i <= int'(sel));
        end
        tb_level   = cnt[sel];
        period_end = step && !clear && ((cnt & low_mask) == low_mask);
    end

endmodule

// File: rtl/tbwd_watchdog.sv
module tbwd_watchdog #(
    parameter int STG_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic clr_stages,
    input  logic clr_flag,
    output logic flag
);

    logic [STG_W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else if (clr_stages) begin
            stg_q <= '0;
        end else if (advance) begin
            stg_q <= stg_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (clr_flag) begin
            flag <= 1'b0;
        end else if (advance && (&stg_q)) begin
            flag <= 1'b1;
        end
    end

endmodule

// File: rtl/tbwd_ctrl.sv
module tbwd_ctrl
    import tbwd_pkg::*;
#(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_sys_on,
    input  logic              cmd_sys_off,
    input  logic              cmd_wdt_run,
    input  logic              cmd_wdt_stop,
    input  logic              cmd_tb_route,
    input  logic              cmd_irq_on,
    input  logic              cmd_irq_off,
    input  logic              cmd_rate_load,
    input  logic [RATE_W-1:0] rate_in,
    input  logic              tb_level,
    input  logic              wd_flag,
    output route_e            route,
    output logic              sys_on,
    output logic              run,
    output logic [RATE_W-1:0] rate,
    output logic              irq_low,
    output logic              irq_oe
);

    route_e route_nxt;
    logic   irq_on;
    logic   src_low;

    always_comb begin
        route_nxt = route;
        if (cmd_wdt_stop) begin
            route_nxt = ST_HALT;
        end else if (cmd_wdt_run) begin
            route_nxt = ST_WATCHDOG;
        end else if (cmd_tb_route) begin
            route_nxt = ST_TIMEBASE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route <= ST_HALT;
        end else begin
            route <= route_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sys_on <= 1'b0;
            irq_on <= 1'b0;
            rate   <= '1;
        end else begin
            if (cmd_sys_off) begin
                sys_on <= 1'b0;
            end else if (cmd_sys_on) begin
                sys_on <= 1'b1;
            end
            if (cmd_irq_off) begin
                irq_on <= 1'b0;
            end else if (cmd_irq_on) begin
                irq_on <= 1'b1;
            end
            if (cmd_rate_load) begin
                rate <= rate_in;
            end
        end
    end

    always_comb begin
        src_low = 1'b0;
        unique case (route)
            ST_HALT:     src_low = 1'b0;
            ST_TIMEBASE: src_low = !tb_level;
            ST_WATCHDOG: src_low = wd_flag;
            default:     src_low = 1'b0;
        endcase
        run     = sys_on && (route != ST_HALT);
        irq_oe  = irq_on;
        irq_low = irq_on && src_low;
    end

endmodule

// File: rtl/tbwd_timer.sv
module tbwd_timer
    import tbwd_pkg::*;
#(
    parameter int CNT_W  = 15,
    parameter int RATE_W = 3,
    parameter int PRE_W  = 3,
    parameter int STG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_slow,
    input  logic              tick_fast,
    input  logic              fast_src,
    input  logic              cmd_sys_on,
    input  logic              cmd_sys_off,
    input  logic              cmd_wdt_run,
    input  logic              cmd_wdt_stop,
    input  logic              cmd_tb_route,
    input  logic              cmd_clr_all,
    input  logic              cmd_clr_tb,
    input  logic              cmd_irq_on,
    input  logic              cmd_irq_off,
    input  logic              cmd_rate_load,
    input  logic [RATE_W-1:0] rate_in,
    output logic              irq_low,
    output logic              irq_oe
);

    localparam int RATES = 1 << RATE_W;

    route_e             route;
    logic               sys_on;
    logic               run;
    logic [RATE_W-1:0]  rate;
    logic               step;
    logic               cnt_clear;
    logic [CNT_W-1:0]   div_cnt;
    logic               tb_level;
    logic               period_end;
    logic               wd_adv;
    logic               wd_flag;

    initial begin
        if (CNT_W < RATES) begin
            $error("CNT_W must cover every rate tap");
        end
    end

    assign cnt_clear = cmd_clr_all || cmd_clr_tb;
    assign wd_adv    = period_end && (route == ST_WATCHDOG);

    tbwd_ctrl #(.RATE_W(RATE_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_sys_on   (cmd_sys_on),
        .cmd_sys_off  (cmd_sys_off),
        .cmd_wdt_run  (cmd_wdt_run),
        .cmd_wdt_stop (cmd_wdt_stop),
        .cmd_tb_route (cmd_tb_route),
        .cmd_irq_on   (cmd_irq_on),
        .cmd_irq_off  (cmd_irq_off),
        .cmd_rate_load(cmd_rate_load),
        .rate_in      (rate_in),
        .tb_level     (tb_level),
        .wd_flag      (wd_flag),
        .route        (route),
        .sys_on       (sys_on),
        .run          (run),
        .rate         (rate),
        .irq_low      (irq_low),
        .irq_oe       (irq_oe)
    );

    tbwd_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .clear    (cnt_clear),
        .fast_src (fast_src),
        .tick_slow(tick_slow),
        .tick_fast(tick_fast),
        .step     (step)
    );

    tbwd_divider #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .clear     (cnt_clear),
        .rate      (rate),
        .cnt       (div_cnt),
        .tb_level  (tb_level),
        .period_end(period_end)
    );

    tbwd_watchdog #(.STG_W(STG_W)) u_wd (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (wd_adv),
        .clr_stages(cmd_clr_all),
        .clr_flag  (cmd_clr_all || cmd_irq_off),
        .flag      (wd_flag)
    );

endmodule

// File: rtl/tbwd_timer_chk.sv
module tbwd_timer_chk
    import tbwd_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_low,
    input logic             irq_oe,
    input logic             cmd_irq_off,
    input logic             cmd_clr_all,
    input logic             cmd_clr_tb,
    input logic             sys_on,
    input route_e           route,
    input logic             wd_flag,
    input logic [CNT_W-1:0] div_cnt
);

    // R12
    low_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_low |-> irq_oe);

    // R10
    irq_off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_irq_off |=> !irq_oe && !wd_flag);

    // R8
    clr_all_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clr_all |=> !wd_flag && (div_cnt == '0));

    // R9
    clr_tb_beats_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clr_tb |=> (div_cnt == '0));

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_flag && !cmd_clr_all && !cmd_irq_off |=> wd_flag);

    // R11
    sys_off_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_on && !cmd_clr_all && !cmd_clr_tb |=> $stable(div_cnt));

    // R6
    halt_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route == ST_HALT) |-> !irq_low);

endmodule

bind tbwd_timer tbwd_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_low    (irq_low),
    .irq_oe     (irq_oe),
    .cmd_irq_off(cmd_irq_off),
    .cmd_clr_all(cmd_clr_all),
    .cmd_clr_tb (cmd_clr_tb),
    .sys_on     (sys_on),
    .route      (route),
    .wd_flag    (wd_flag),
    .div_cnt    (div_cnt)
);

// File: tb/tbwd_timer_test.sv
module tbwd_timer_test;

    localparam int CW = 10;

    localparam int C_SYS_ON   = 0;
    localparam int C_SYS_OFF  = 1;
    localparam int C_WDT_RUN  = 2;
    localparam int C_WDT_STOP = 3;
    localparam int C_TB_ROUTE = 4;
    localparam int C_CLR_ALL  = 5;
    localparam int C_CLR_TB   = 6;
    localparam int C_IRQ_ON   = 7;
    localparam int C_IRQ_OFF  = 8;
    localparam int C_RATE     = 9;
    localparam int C_IRQ_BOTH = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_slow = 1'b1;
    logic tick_fast = 1'b1;
    logic fast_src = 1'b0;
    logic cmd_sys_on = 0, cmd_sys_off = 0, cmd_wdt_run = 0, cmd_wdt_stop = 0;
    logic cmd_tb_route = 0, cmd_clr_all = 0, cmd_clr_tb = 0;
    logic cmd_irq_on = 0, cmd_irq_off = 0, cmd_rate_load = 0;
    logic [2:0] rate_in = 3'd0;
    logic irq_low, irq_oe;

    int n_chk = 0;
    int n_bad = 0;
    int m = 0;
    bit b_sys = 0;
    bit b_run = 0;
    int rate_cur = 7;
    bit done = 0;

    always #2 clk = ~clk;

    tbwd_timer #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
        .fast_src(fast_src), .cmd_sys_on(cmd_sys_on), .cmd_sys_off(cmd_sys_off),
        .cmd_wdt_run(cmd_wdt_run), .cmd_wdt_stop(cmd_wdt_stop),
        .cmd_tb_route(cmd_tb_route), .cmd_clr_all(cmd_clr_all),
        .cmd_clr_tb(cmd_clr_tb), .cmd_irq_on(cmd_irq_on),
        .cmd_irq_off(cmd_irq_off), .cmd_rate_load(cmd_rate_load),
        .rate_in(rate_in), .irq_low(irq_low), .irq_oe(irq_oe)
    );

    task automatic check(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at m=%0d rate=%0d: actual %0b expected %0b",
                     tag, m, rate_cur, act, exp);
        end
    endtask

    function automatic logic exp_tb_low();
        int cnt = fast_src ? (m >> 3) : m;
        int k = CW - 1 - rate_cur;
        return ((cnt >> k) & 1) == 0;
    endfunction

    function automatic int period();
        return 1 << (CW - rate_cur);
    endfunction

    // Called at a negedge; returns at the next negedge
    task automatic issue(int c, logic [2:0] r = 3'd0);
        case (c)
            C_SYS_ON:   cmd_sys_on   = 1;
            C_SYS_OFF:  cmd_sys_off  = 1;
            C_WDT_RUN:  cmd_wdt_run  = 1;
            C_WDT_STOP: cmd_wdt_stop = 1;
            C_TB_ROUTE: cmd_tb_route = 1;
            C_CLR_ALL:  cmd_clr_all  = 1;
            C_CLR_TB:   cmd_clr_tb   = 1;
            C_IRQ_ON:   cmd_irq_on   = 1;
            C_IRQ_OFF:  cmd_irq_off  = 1;
            C_IRQ_BOTH: begin cmd_irq_on = 1; cmd_irq_off = 1; end
            C_RATE:     begin cmd_rate_load = 1; rate_in = r; end
            default: ;
        endcase
        @(negedge clk);
        {cmd_sys_on, cmd_sys_off, cmd_wdt_run, cmd_wdt_stop, cmd_tb_route} = '0;
        {cmd_clr_all, cmd_clr_tb, cmd_irq_on, cmd_irq_off, cmd_rate_load} = '0;
        if (b_sys && b_run) m++;
        case (c)
            C_SYS_ON:   b_sys = 1;
            C_SYS_OFF:  b_sys = 0;
            C_WDT_RUN:  b_run = 1;
            C_WDT_STOP: b_run = 0;
            C_TB_ROUTE: b_run = 1;
            C_CLR_ALL:  m = 0;
            C_CLR_TB:   m = 0;
            C_RATE:     rate_cur = int'(r);
            default: ;
        endcase
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (b_sys && b_run) m++;
        end
    endtask

    task automatic tb_sweep(int r, bit f, string tag);
        fast_src = f;
        issue(C_RATE, 3'(r));
        issue(C_TB_ROUTE);
        issue(C_CLR_ALL);
        for (int i = 0; i < 2 * period() * (f ? 8 : 1); i++) begin
            check(tag, irq_low, exp_tb_low());
            run(1);
        end
    endtask

    task automatic wd_sweep(int r);
        int lim;
        fast_src = 0;
        issue(C_RATE, 3'(r));
        issue(C_WDT_RUN);
        issue(C_IRQ_ON);
        issue(C_CLR_ALL);
        lim = 4 * period();
        for (int i = 0; i <= lim + 2; i++) begin
            check("R4 time-out edge", irq_low, m >= lim);
            run(1);
        end
        run(7);
        check("R5 flag held", irq_low, 1'b1);
        issue(C_CLR_ALL);
        check("R8 clear-all drops flag", irq_low, 1'b0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 oe after reset", irq_oe, 1'b0);
        check("R1 low after reset", irq_low, 1'b0);
        issue(C_IRQ_ON);
        check("R1 halted routes nothing", irq_low, 1'b0);

        // R1 default rate code 7, R2 square wave
        issue(C_SYS_ON);
        issue(C_TB_ROUTE);
        issue(C_CLR_ALL);
        rate_cur = 7;
        check("R9 count zero after clear", irq_low, 1'b1);
        for (int i = 0; i < 2 * period(); i++) begin
            check("R1 default rate", irq_low, exp_tb_low());
            run(1);
        end

        for (int r = 0; r < 8; r++) tb_sweep(r, 1'b0, "R2 time-base level");
        // R3 prescaled fast source
        tb_sweep(7, 1'b1, "R3 prescale");
        tb_sweep(4, 1'b1, "R3 prescale");
        fast_src = 0;

        for (int r = 0; r < 8; r++) wd_sweep(r);

        // R8 time-base-only clear keeps watchdog stages
        issue(C_RATE, 3'd6);
        issue(C_WDT_RUN);
        issue(C_CLR_ALL);
        run(2 * period() + 1);
        issue(C_CLR_TB);
        check("R9 clear-tb zero", irq_low, 1'b0);
        run(2 * period() - 1);
        check("R8 stages kept, not yet", irq_low, 1'b0);
        run(1);
        check("R8 stages kept, time-out", irq_low, 1'b1);

        // R7 time-base route ignores the set flag
        issue(C_TB_ROUTE);
        for (int i = 0; i < 2 * period(); i++) begin
            check("R7 route over flag", irq_low, exp_tb_low());
            run(1);
        end

        // R6 stop freezes, resume continues
        issue(C_RATE, 3'd7);
        issue(C_CLR_ALL);
        run(5);
        issue(C_WDT_STOP);
        for (int i = 0; i < 19; i++) begin
            check("R6 halt releases", irq_low, 1'b0);
            run(1);
        end
        issue(C_TB_ROUTE);
        for (int i = 0; i < 16; i++) begin
            check("R6 resume from frozen", irq_low, exp_tb_low());
            run(1);
        end

        // R11 system off freezes the level
        issue(C_SYS_OFF);
        for (int i = 0; i < 13; i++) begin
            check("R11 frozen while off", irq_low, exp_tb_low());
            run(1);
        end
        issue(C_SYS_ON);
        for (int i = 0; i < 16; i++) begin
            check("R11 resume", irq_low, exp_tb_low());
            run(1);
        end

        // R10 disable clears flag, enable restores line
        issue(C_WDT_RUN);
        issue(C_CLR_ALL);
        run(4 * period());
        check("R10 timed out", irq_low, 1'b1);
        issue(C_IRQ_OFF);
        check("R10 oe off", irq_oe, 1'b0);
        check("R12 no low without oe", irq_low, 1'b0);
        issue(C_IRQ_ON);
        check("R10 oe on", irq_oe, 1'b1);
        check("R10 flag gone", irq_low, 1'b0);
        issue(C_IRQ_BOTH);
        check("R10 off wins", irq_oe, 1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule